// File: doc/BRIEF.md
# Bresenham Line Stepper

This block is the line-drawing engine of a bitplane blitter. It plots one straight line into word-addressed memory, one pixel at a time. When software pulses `start`, the block latches a line description:

- the octant,
- a single-pixel-per-row flag,
- the initial Bresenham error,
- the two error increments,
- the row stride,
- the starting word address and pixel bit index,
- a step count,
- an 8-bit logic function.

For every pixel it draws, the block reads the destination word. It combines that word with a one-hot pixel mask through the logic function and writes the result back. It then advances the Bresenham position.

The controller has four states:

- `ST_IDLE` waits for `start`.
- `ST_FETCH` issues the memory read.
- `ST_MERGE` writes the merged word.
- `ST_STEP` moves the position, updates the error and counts down.

The transitions are:

- idle→fetch on an accepted start.
- fetch→merge always.
- merge→step always.
- step→fetch when the next pixel is to be drawn.
- step→step when drawing is suppressed (single-pixel-per-row mode).
- step→idle on the last step, which also pulses `done`.

Top module: `line_stepper`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are 0 and `zero_flag` is 1.
- R2: A `start` pulse while idle latches every configuration input, and `busy` is 1 from the following cycle. A `start` while busy has no effect on the line being drawn.
- R3: Each drawn pixel takes three cycles:
  - `mem_rd` is high for one cycle with the pixel's word address.
  - `mem_rdata` is expected in the next cycle, and `mem_wr` is high in that same cycle at the same address.
  - A step cycle follows.
  
  A step that draws nothing takes one cycle.
- R4: The written word is computed per bit. Bit i is `func[{a_i,b_i,c_i}]`, where a_i is the pixel mask bit, b_i is 1 and c_i is the read word's bit i. The pixel mask has only bit (DATA_W-1-index) set, so index 0 is the most significant bit.
- R5: The octant bits control the step directions:
  - `octant[2]`=1 means x is the major axis.
  - `octant[0]`=1 means the major axis steps negative.
  - `octant[1]`=1 means the minor axis steps negative.
  
  Every step moves the major axis. If the error is negative, `inc_straight` is added to it. Otherwise the minor axis also moves and `inc_diag` is added.
- R6: A step to the left decrements the 4-bit pixel index, and decrements the address when the index wraps from 0. A step to the right increments the index, and increments the address when it wraps from 15.
- R7: A step up subtracts `row_stride` from the address. A step down adds it.
- R8: With `one_dot`=1, after a pixel is drawn no further pixel is drawn until a step that moves vertically.
- R9: The step count decrements on every step. On the step that takes it to zero, `busy` falls and `done` is high for exactly one cycle. A count of 0 means 2^CNT_W steps.
- R10: `zero_flag` is set to 1 when a line starts, and is cleared by any nonzero written word.
- R11: `err_init` is a signed value one bit narrower than the error register, and it is sign-extended when the line starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a line (honoured only when idle) |
| octant | input | 3 | [2] x-major, [1] minor negative, [0] major negative |
| one_dot | input | 1 | Draw at most one pixel per row |
| err_init | input | ERR_W-1 | Initial signed error term |
| inc_straight | input | ERR_W | Error increment for a major-only step |
| inc_diag | input | ERR_W | Error increment for a diagonal step |
| row_stride | input | ADDR_W | Address distance between rows |
| start_addr | input | ADDR_W | Word address of the first pixel |
| start_bit | input | IDX_W | Pixel index of the first pixel (0 = MSB) |
| pixel_count | input | CNT_W | Number of steps (0 = 2^CNT_W) |
| func | input | 8 | Logic function table |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Line in progress |
| done | output | 1 | One-cycle completion pulse |
| zero_flag | output | 1 | All words written so far were zero |

## Verification
A start sampled at clock edge E0 sets `busy` and `zero_flag`, which are visible just after E0. `done` rises after edge E0 + 3·D + S, where D is the number of drawn pixels and S the number of steps that drew nothing. The bench derives D and S from its own coordinate-based Bresenham walk, counts clock edges from the start, and compares the count at the falling edge where `done` first appears. Memory contents, the number of writes and `zero_flag` are compared against that walk once `done` is seen. The bench then checks that `done` has dropped one cycle later. All eight octants are swept with and without single-pixel-per-row mode, at several slopes and start indices, plus a maximum-length line and a run with a mid-line start pulse.

// File: rtl/line_pkg.sv
package line_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MERGE = 2'd2,
        ST_STEP  = 2'd3
    } lstate_e;
endpackage

// File: rtl/line_merge.sv
// Per-bit three-input logic function: bit i of y = func[{a[i], b[i], c[i]}].
module line_merge #(
    parameter int DATA_W = 16
) (
    input  logic [7:0]        func,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] c,
    output logic [DATA_W-1:0] y
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign y[i] = func[{a[i], b[i], c[i]}];
    end
endmodule

// File: rtl/line_advance.sv
// Combinational Bresenham position update. DATA_W must be a power of two so
// the pixel index wraps naturally.
module line_advance #(
    parameter int ADDR_W = 16,
    parameter int ERR_W  = 16,
    parameter int IDX_W  = 4
) (
    input  logic [2:0]              octant,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [IDX_W-1:0]        idx,
    input  logic signed [ERR_W-1:0] err,
    input  logic signed [ERR_W-1:0] inc_straight,
    input  logic signed [ERR_W-1:0] inc_diag,
    input  logic [ADDR_W-1:0]       row_stride,
    output logic [ADDR_W-1:0]       addr_n,
    output logic [IDX_W-1:0]        idx_n,
    output logic signed [ERR_W-1:0] err_n,
    output logic                    vert
);
    localparam logic [IDX_W-1:0] IDX_TOP = {IDX_W{1'b1}};

    logic              diag;
    logic              horiz;
    logic              left;
    logic              up;
    logic [ADDR_W-1:0] addr_h;

    always_comb begin
        diag  = ~err[ERR_W-1];
        horiz = octant[2] | diag;
        left  = octant[2] ? octant[0] : octant[1];
        vert  = ~octant[2] | diag;
        up    = octant[2] ? octant[1] : octant[0];
        err_n = diag ? (err + inc_diag) : (err + inc_straight);

        idx_n  = idx;
        addr_h = addr;
        if (horiz) begin
            if (left) begin
                idx_n = idx - 1'b1;
                if (idx == '0) addr_h = addr - 1'b1;
            end else begin
                idx_n = idx + 1'b1;
                if (idx == IDX_TOP) addr_h = addr + 1'b1;
            end
        end

        if (vert) addr_n = up ? (addr_h - row_stride) : (addr_h + row_stride);
        else      addr_n = addr_h;
    end
endmodule

// File: rtl/line_stepper.sv
module line_stepper
    import line_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int ERR_W  = 16,
    parameter int CNT_W  = 10,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        octant,
    input  logic              one_dot,
    input  logic [ERR_W-2:0]  err_init,
    input  logic [ERR_W-1:0]  inc_straight,
    input  logic [ERR_W-1:0]  inc_diag,
    input  logic [ADDR_W-1:0] row_stride,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [IDX_W-1:0]  start_bit,
    input  logic [CNT_W-1:0]  pixel_count,
    input  logic [7:0]        func,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              zero_flag
);
    localparam logic [DATA_W-1:0] MSB_ONE  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(1);

    lstate_e state_q, state_d;

    // Latched line description
    logic [2:0]              oct_q;
    logic                    one_dot_q;
    logic signed [ERR_W-1:0] inc_s_q;
    logic signed [ERR_W-1:0] inc_d_q;
    logic [ADDR_W-1:0]       stride_q;
    logic [7:0]              func_q;

    // Walking position
    logic [ADDR_W-1:0]       addr_q;
    logic [IDX_W-1:0]        idx_q;
    logic signed [ERR_W-1:0] err_q;
    logic [CNT_W-1:0]        cnt_q;
    logic                    draw_q;

    logic [ADDR_W-1:0]       addr_n;
    logic [IDX_W-1:0]        idx_n;
    logic signed [ERR_W-1:0] err_n;
    logic                    vert;
    logic                    draw_nxt;
    logic                    last_step;
    logic [DATA_W-1:0]       pix_mask;
    logic [DATA_W-1:0]       merged;

    line_advance #(
        .ADDR_W (ADDR_W),
        .ERR_W  (ERR_W),
        .IDX_W  (IDX_W)
    ) u_adv (
        .octant       (oct_q),
        .addr         (addr_q),
        .idx          (idx_q),
        .err          (err_q),
        .inc_straight (inc_s_q),
        .inc_diag     (inc_d_q),
        .row_stride   (stride_q),
        .addr_n       (addr_n),
        .idx_n        (idx_n),
        .err_n        (err_n),
        .vert         (vert)
    );

    assign pix_mask = MSB_ONE >> idx_q;

    line_merge #(.DATA_W(DATA_W)) u_merge (
        .func (func_q),
        .a    (pix_mask),
        .b    ({DATA_W{1'b1}}),
        .c    (mem_rdata),
        .y    (merged)
    );

    assign draw_nxt  = vert | (draw_q & ~one_dot_q);
    assign last_step = (cnt_q == CNT_LAST);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_MERGE;
            ST_MERGE: state_d = ST_STEP;
            ST_STEP: begin
                if (last_step)     state_d = ST_IDLE;
                else if (draw_nxt) state_d = ST_FETCH;
                else               state_d = ST_STEP;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        busy      = 1'b1;
        mem_addr  = addr_q;
        mem_wdata = merged;
        unique case (state_q)
            ST_IDLE:  busy   = 1'b0;
            ST_FETCH: mem_rd = 1'b1;
            ST_MERGE: mem_wr = 1'b1;
            ST_STEP:  ;
        endcase
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oct_q     <= '0;
            one_dot_q <= 1'b0;
            inc_s_q   <= '0;
            inc_d_q   <= '0;
            stride_q  <= '0;
            func_q    <= '0;
            addr_q    <= '0;
            idx_q     <= '0;
            err_q     <= '0;
            cnt_q     <= '0;
            draw_q    <= 1'b0;
            done      <= 1'b0;
            zero_flag <= 1'b1;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        oct_q     <= octant;
                        one_dot_q <= one_dot;
                        inc_s_q   <= inc_straight;
                        inc_d_q   <= inc_diag;
                        stride_q  <= row_stride;
                        func_q    <= func;
                        addr_q    <= start_addr;
                        idx_q     <= start_bit;
                        err_q     <= {err_init[ERR_W-2], err_init};
                        cnt_q     <= pixel_count;
                        draw_q    <= 1'b1;
                        zero_flag <= 1'b1;
                    end
                end
                ST_FETCH: ;
                ST_MERGE: begin
                    if (|merged) zero_flag <= 1'b0;
                end
                ST_STEP: begin
                    addr_q <= addr_n;
                    idx_q  <= idx_n;
                    err_q  <= err_n;
                    cnt_q  <= cnt_q - 1'b1;
                    draw_q <= draw_nxt;
                    if (last_step) done <= 1'b1;
                end
            endcase
        end
    end

    // Guards
    p_rmw_same_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));

    p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_zero_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_wdata != '0) |=> !zero_flag);

    p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
endmodule

// File: tb/line_stepper_tb.sv
`timescale 1ns/1ps
module line_stepper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  octant = '0;
    logic        one_dot = 1'b0;
    logic [14:0] err_init = '0;
    logic [15:0] inc_straight = '0;
    logic [15:0] inc_diag = '0;
    logic [15:0] row_stride = '0;
    logic [15:0] start_addr = '0;
    logic [3:0]  start_bit = '0;
    logic [9:0]  pixel_count = '0;
    logic [7:0]  func = '0;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        busy, done, zero_flag;
    logic        mem_clr = 1'b0;

    logic [15:0] mem [0:255];
    logic [15:0] exp_mem [0:255];
    int          wr_count = 0;
    int          checks = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    line_stepper u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .octant(octant), .one_dot(one_dot),
        .err_init(err_init), .inc_straight(inc_straight), .inc_diag(inc_diag),
        .row_stride(row_stride), .start_addr(start_addr), .start_bit(start_bit),
        .pixel_count(pixel_count), .func(func), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .zero_flag(zero_flag)
    );

    // Memory model: read data registered one cycle after the request
    always @(posedge clk) begin
        if (mem_clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
        end else begin
            if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
            if (mem_wr) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wr_count <= wr_count + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [15:0] fmerge(input logic [7:0] f, input logic [15:0] a,
                                           input logic [15:0] b, input logic [15:0] c);
        logic [15:0] y;
        for (int i = 0; i < 16; i++) y[i] = f[{a[i], b[i], c[i]}];
        return y;
    endfunction

    // Draw one line and compare against a coordinate-based Bresenham walk.
    task automatic run_line(input int oct, input int od, input int dmaj, input int dmin,
                            input int saddr, input int sbit, input int cnt,
                            input logic [7:0] f, input bit poke);
        int err0, is_v, id_v, steps, d, s, px, py, e, a, cyc, wr0, mism;
        bit draw, nz, diag, vm, xmaj, mjn, mnn;
        logic [15:0] w;
        err0 = 4*dmin - 2*dmaj;
        is_v = 4*dmin;
        id_v = 4*(dmin - dmaj);
        steps = (cnt == 0) ? 1024 : cnt;
        xmaj = oct[2]; mnn = oct[1]; mjn = oct[0];
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        px = sbit; py = 0; e = err0; draw = 1; nz = 0; d = 0; s = 0;
        for (int k = 0; k < steps; k++) begin
            if (draw) begin
                a = (saddr + py*8 + (px >>> 4)) & 255;
                w = fmerge(f, 16'h8000 >> (px & 15), 16'hFFFF, exp_mem[a]);
                exp_mem[a] = w;
                if (w != 0) nz = 1;
                d++;
                if (od != 0) draw = 0;
            end else s++;
            diag = (e >= 0);
            e += diag ? id_v : is_v;
            vm = 0;
            if (xmaj) begin
                px += mjn ? -1 : 1;
                if (diag) begin py += mnn ? -1 : 1; vm = 1; end
            end else begin
                py += mjn ? -1 : 1; vm = 1;
                if (diag) px += mnn ? -1 : 1;
            end
            if (vm) draw = 1;
        end

        @(negedge clk);
        octant = oct[2:0]; one_dot = od[0]; err_init = 15'(err0);
        inc_straight = 16'(is_v); inc_diag = 16'(id_v); row_stride = 16'd8;
        start_addr = 16'(saddr); start_bit = 4'(sbit); pixel_count = 10'(cnt); func = f;
        wr0 = wr_count;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R2 busy after start", busy, 1);
        chk(zero_flag === 1'b1, "R10 zero flag set at start", zero_flag, 1);
        cyc = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (poke && cyc == 3) begin
                // R2: start while busy with a different line must be ignored
                start = 1'b1; octant = ~octant; start_addr = 16'd3; func = 8'h00;
            end else start = 1'b0;
            if (done) break;
        end
        start = 1'b0;
        chk(cyc == 3*d + s, "R3/R9 cycles to done", cyc, 3*d + s);
        chk(busy === 1'b0, "R9 busy low with done", busy, 0);
        chk(wr_count - wr0 == d, "R3/R8 write count", wr_count - wr0, d);
        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) begin
            if (mism == 0) $display("  first mismatch at word %0d: %h vs %h", i, mem[i], exp_mem[i]);
            mism++;
        end
        chk(mism == 0, poke ? "R2 memory after ignored start" : "R4/R5/R6/R7/R8/R11 memory image", mism, 0);
        chk(zero_flag === !nz, "R10 zero flag after line", zero_flag, !nz);
        @(negedge clk);
        chk(done === 1'b0, "R9 done is one cycle", done, 0);
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        mem_clr = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        mem_clr = 1'b0;
        rst_n = 1'b1;
        // R1: reset state
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(done === 1'b0, "R1 done", done, 0);
        chk(mem_rd === 1'b0, "R1 mem_rd", mem_rd, 0);
        chk(mem_wr === 1'b0, "R1 mem_wr", mem_wr, 0);
        chk(zero_flag === 1'b1, "R1 zero_flag", zero_flag, 1);

        // R10: all-zero function on cleared memory keeps the flag set
        run_line(4, 0, 6, 2, 40, 14, 7, 8'h00, 1'b0);

        // R5/R6/R7/R8: every octant, both modes, several slopes
        for (int oct = 0; oct < 8; oct++)
            for (int od = 0; od < 2; od++)
                for (int p = 0; p < 3; p++) begin
                    int dj, dn;
                    dj = (p == 0) ? 11 : (p == 1) ? 7 : 5;
                    dn = (p == 0) ? 4  : (p == 1) ? 7 : 0;   // p==2: R11 negative init
                    run_line(oct, od, dj, dn, 128, (oct*5 + p*3) % 16, dj + 1,
                             (od != 0) ? 8'hFA : 8'h5A, (oct == 5 && od == 0 && p == 0));
                end

        // R9: count of zero means 1024 steps
        run_line(1, 0, 1023, 300, 64, 0, 0, 8'h5A, 1'b0);
        // R6: long x-major lines crossing several words both ways
        run_line(4, 1, 40, 3, 20, 15, 41, 8'hFA, 1'b0);
        run_line(5, 0, 40, 9, 200, 0, 41, 8'h5A, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule